// File: doc/BRIEF.md
# Dual-Mode Serial Port with Independent Enable Gating

This block is a byte-wide serial port that works in one of two modes. In asynchronous mode it sends and receives framed characters at a fixed oversampled bit rate. In clock-synchronous mode it acts as clock master and emits a shift clock alongside the data. The bit rate comes from a plain clock divider. A one-byte transmit buffer feeds a transmit shift register. A separate receive path assembles incoming bytes.

Three control inputs set how the logic behaves: a port enable, a transmit enable and a receive enable. The port enable only decides whether the pins are driven. It does not stop or reset the transmitter, so a byte written while the port is off is still shifted out internally. If the port is turned back on mid-frame, the remaining bits of that frame appear on the data pin. Receive stops when either the receive enable or the port enable is low. In synchronous mode the transmit clock circuit also times reception, so the transmitter keeps running until both transmit and receive enables are low.

Top module: `sio_ctrl`

## Requirements
- R1: After reset `txd` and `sclk` are 1, `txd_oe` and `sclk_oe` are 0, `tx_empty` is 1, and `tx_busy` and `rx_valid` are 0.
- R2: With `sync_mode`=0, a frame on `txd` is one start bit (0), then 8 data bits least significant first, then one stop bit (1). Each bit lasts 16*DIV clock cycles, and the line idles at 1.
- R3: While `port_en`=0, `txd` stays 1 and `txd_oe` stays 0. A write with `tx_en`=1 is still accepted: the byte moves into the shift register (`tx_busy` goes to 1 and `tx_empty` returns to 1), and shifting proceeds internally.
- R4: When `port_en` rises during an internally shifting frame, `txd` carries the remaining bits of that frame at their normal bit times.
- R5: With `sync_mode`=0, clearing `tx_en` clears the shift register, the bit counter and the buffer on the next edge: `tx_busy`=0, `tx_empty`=1 and `txd` returns to idle. Writes made while `tx_en`=0 are dropped.
- R6: With `sync_mode`=0, the receiver samples `rxd` near mid-bit using the 16x tick. When a frame ends with a stop bit of 1, it pulses `rx_valid` for exactly one cycle, with the byte on `rx_data`. A frame whose stop bit is 0 produces no pulse.
- R7: While `rx_en`=0 or `port_en`=0, `rx_valid` stays 0 and no byte is received.
- R8: With `sync_mode`=1, each byte produces exactly 8 clock pulses on `sclk`, and there is no start or stop bit. Each bit is a low half of DIV cycles followed by a high half of DIV cycles. Data changes on the falling edge, least significant bit first, and `sclk` idles at 1. `sclk` stays 1 and `sclk_oe` stays 0 unless both `port_en` and `sync_mode` are 1.
- R9: With `sync_mode`=1, `rxd` is sampled at each rising edge of the internal transmit clock. After the 8th edge, `rx_valid` pulses with the assembled byte, least significant bit first.
- R10: With `sync_mode`=1, clearing only `tx_en` while `rx_en`=1 lets the frame in progress run to the end. Clearing both enables stops it on the next edge.
- R11: A byte written while a frame is in progress waits in the buffer and starts right after the current stop bit. A write while the buffer is full is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Connects the serial logic to the pins |
| tx_en | input | 1 | Transmit enable; low clears the transmitter (see R5, R10) |
| rx_en | input | 1 | Receive enable |
| sync_mode | input | 1 | 1 = clock-synchronous master, 0 = asynchronous |
| wr_valid | input | 1 | Write strobe for the transmit buffer |
| wr_data | input | DATA_W | Byte to transmit |
| rxd | input | 1 | Serial receive data |
| txd | output | 1 | Serial transmit data pin |
| txd_oe | output | 1 | Drive enable for `txd` |
| sclk | output | 1 | Shift clock pin in synchronous mode |
| sclk_oe | output | 1 | Drive enable for `sclk` |
| tx_empty | output | 1 | Transmit buffer can take a byte |
| tx_busy | output | 1 | Transmit shift register is shifting |
| rx_valid | output | 1 | One-cycle pulse when a byte has been received |
| rx_data | output | DATA_W | Last received byte |

## Verification
Seeded random bytes in both modes, plus all-zero and all-one bytes, check the bit order and the frame boundaries. A transmit loop-back in synchronous mode shows that receive sampling is tied to the transmit clock edges. Stimulus sequences that toggle the enables at mid-frame points tell apart the three gating cases: pins disconnected while shifting continues, a full transmitter clear, and a clear that synchronous reception holds off. Directed back-to-back writes, a write into a full buffer and a frame with a bad stop bit cover the buffering and framing edge cases.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic {MODE_ASYNC = 1'b0, MODE_SYNC = 1'b1} sio_mode_e;
  localparam int OVS   = 16;
  localparam int SUB_W = $clog2(OVS);
endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || tick) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sio_tx.sv
module sio_tx
  import sio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  sio_mode_e         mode,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              line,
  output logic              sclk_int,
  output logic              rise_stb,
  output logic              frame_start,
  output logic              buf_empty,
  output logic              busy_o
);
  localparam int FR_W = DATA_W + 2;
  localparam int BC_W = $clog2(FR_W + 1);

  logic              full;
  logic [DATA_W-1:0] buf_q;
  logic              busy;
  logic [FR_W-1:0]   frame;
  logic [BC_W-1:0]   bitcnt;
  logic [SUB_W-1:0]  sub;

  logic              is_sync;
  logic              keep;
  logic [BC_W-1:0]   last_bit;
  logic [SUB_W-1:0]  last_sub;
  logic              bit_end;
  logic              frame_end;
  logic              load;

  assign is_sync   = (mode == MODE_SYNC);
  // in synchronous mode the transmit clock also serves reception
  assign keep      = tx_en || (is_sync && rx_en);
  assign last_bit  = is_sync ? BC_W'(DATA_W - 1) : BC_W'(FR_W - 1);
  assign last_sub  = is_sync ? SUB_W'(1) : SUB_W'(OVS - 1);
  assign bit_end   = busy && tick && (sub == last_sub);
  assign frame_end = bit_end && (bitcnt == last_bit);
  assign load      = full && tick && (!busy || frame_end);

  always_ff @(posedge clk) begin
    if (rst || !keep) begin
      full   <= 1'b0;
      buf_q  <= '0;
      busy   <= 1'b0;
      frame  <= '1;
      bitcnt <= '0;
      sub    <= '0;
    end else begin
      if (load) begin
        busy   <= 1'b1;
        frame  <= is_sync ? {2'b11, buf_q} : {1'b1, buf_q, 1'b0};
        bitcnt <= '0;
        sub    <= '0;
      end else if (frame_end) begin
        busy   <= 1'b0;
        frame  <= '1;
      end else if (bit_end) begin
        frame  <= {1'b1, frame[FR_W-1:1]};
        bitcnt <= bitcnt + 1'b1;
        sub    <= '0;
      end else if (busy && tick) begin
        sub    <= sub + 1'b1;
      end

      if (wr_valid && !full) begin
        full  <= 1'b1;
        buf_q <= wr_data;
      end else if (load) begin
        full  <= 1'b0;
      end
    end
  end

  assign line        = frame[0];
  assign sclk_int    = !(busy && is_sync && (sub == '0));
  assign rise_stb    = busy && is_sync && tick && (sub == '0);
  assign frame_start = load;
  assign buf_empty   = !full;
  assign busy_o      = busy;

  assert_line_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick && keep) |=> $stable(line));

  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    !keep |=> (buf_empty && !busy_o));
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  sio_mode_e         mode,
  input  logic              enable,
  input  logic              rxd,
  input  logic              rise_stb,
  input  logic              frame_start,
  output logic              valid,
  output logic [DATA_W-1:0] data
);
  localparam int BC_W = $clog2(DATA_W + 2);
  localparam logic [SUB_W-1:0] MID = SUB_W'(OVS / 2 - 1);

  logic [1:0]        rsync;
  logic              rs;
  logic              is_sync;
  logic              active;
  logic              armed;
  logic [SUB_W-1:0]  sub;
  logic [BC_W-1:0]   bitcnt;
  logic [DATA_W-1:0] sh;

  assign rs      = rsync[1];
  assign is_sync = (mode == MODE_SYNC);

  always_ff @(posedge clk) begin
    if (rst) rsync <= 2'b11;
    else     rsync <= {rsync[0], rxd};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0; armed <= 1'b0; sub <= '0; bitcnt <= '0;
      sh <= '0; valid <= 1'b0; data <= '0;
    end else if (!enable) begin
      active <= 1'b0; armed <= 1'b0; sub <= '0; bitcnt <= '0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (is_sync) begin
        active <= 1'b0;
        sub    <= '0;
        if (frame_start) begin
          bitcnt <= '0;
        end else if (rise_stb) begin
          sh <= {rs, sh[DATA_W-1:1]};
          if (bitcnt == BC_W'(DATA_W - 1)) begin
            valid  <= 1'b1;
            data   <= {rs, sh[DATA_W-1:1]};
            bitcnt <= '0;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
      end else if (tick) begin
        if (!active) begin
          armed <= rs;
          if (!rs && armed) begin
            active <= 1'b1;
            sub    <= '0;
            bitcnt <= '0;
          end
        end else begin
          sub <= sub + 1'b1;
          if (sub == MID) begin
            if (bitcnt == '0) begin
              if (rs) active <= 1'b0;
              else    bitcnt <= 1'b1;
            end else if (bitcnt == BC_W'(DATA_W + 1)) begin
              active <= 1'b0;
              armed  <= 1'b0;
              if (rs) begin
                valid <= 1'b1;
                data  <= sh;
              end
            end else begin
              sh     <= {rs, sh[DATA_W-1:1]};
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
      end
    end
  end

  assert_valid_single_R6: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  assert_rx_off_R7: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !valid);

  assert_sync_edge_R9: assert property (@(posedge clk) disable iff (rst)
    (valid && $past(is_sync)) |-> $past(rise_stb));
endmodule

// File: rtl/sio_ctrl.sv
module sio_ctrl
  import sio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_en,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              sync_mode,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rxd,
  output logic              txd,
  output logic              txd_oe,
  output logic              sclk,
  output logic              sclk_oe,
  output logic              tx_empty,
  output logic              tx_busy,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data
);
  sio_mode_e mode;
  logic      tick;
  logic      line;
  logic      sclk_int;
  logic      rise_stb;
  logic      frame_start;

  assign mode = sync_mode ? MODE_SYNC : MODE_ASYNC;

  sio_baud #(.DIV(DIV)) u_baud (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  sio_tx #(.DATA_W(DATA_W)) u_tx (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .mode        (mode),
    .tx_en       (tx_en),
    .rx_en       (rx_en),
    .wr_valid    (wr_valid),
    .wr_data     (wr_data),
    .line        (line),
    .sclk_int    (sclk_int),
    .rise_stb    (rise_stb),
    .frame_start (frame_start),
    .buf_empty   (tx_empty),
    .busy_o      (tx_busy)
  );

  sio_rx #(.DATA_W(DATA_W)) u_rx (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .mode        (mode),
    .enable      (rx_en && port_en),
    .rxd         (rxd),
    .rise_stb    (rise_stb),
    .frame_start (frame_start),
    .valid       (rx_valid),
    .data        (rx_data)
  );

  // pin stage: the port enable only gates what reaches the pins
  always_ff @(posedge clk) begin
    if (rst) begin
      txd     <= 1'b1;
      txd_oe  <= 1'b0;
      sclk    <= 1'b1;
      sclk_oe <= 1'b0;
    end else begin
      txd     <= port_en ? line : 1'b1;
      txd_oe  <= port_en;
      sclk    <= (port_en && sync_mode) ? sclk_int : 1'b1;
      sclk_oe <= port_en && sync_mode;
    end
  end

  assert_txd_parked_R3: assert property (@(posedge clk) disable iff (rst)
    !port_en |=> (txd && !txd_oe));

  assert_sclk_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !sync_mode |=> (sclk && !sclk_oe));
endmodule

// File: tb/sio_ctrl_bench.sv
module sio_ctrl_bench;
  localparam int CLK_NS = 10;
  localparam int DIV    = 4;
  localparam int DW     = 8;
  localparam int BA     = 16 * DIV;
  localparam int BS     = 2 * DIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic port_en = 0, tx_en = 0, rx_en = 0, sync_mode = 0, wr_valid = 0;
  logic [DW-1:0] wr_data = '0;
  logic loop = 0, rxd_drv = 1;
  logic rxd, txd, txd_oe, sclk, sclk_oe, tx_empty, tx_busy, rx_valid;
  logic [DW-1:0] rx_data;

  assign rxd = loop ? txd : rxd_drv;

  always #(CLK_NS/2) clk = ~clk;

  sio_ctrl #(.DATA_W(DW), .DIV(DIV)) u_sio_ctrl (
    .clk(clk), .rst(rst), .port_en(port_en), .tx_en(tx_en), .rx_en(rx_en),
    .sync_mode(sync_mode), .wr_valid(wr_valid), .wr_data(wr_data), .rxd(rxd),
    .txd(txd), .txd_oe(txd_oe), .sclk(sclk), .sclk_oe(sclk_oe),
    .tx_empty(tx_empty), .tx_busy(tx_busy), .rx_valid(rx_valid), .rx_data(rx_data)
  );

  int total = 0, fails = 0, rx_cnt = 0, rises = 0;
  logic [DW-1:0] rx_last = '0;
  logic sclk_prev = 1'b1;
  bit done = 0;

  always @(posedge clk) begin
    if (rx_valid) begin rx_cnt <= rx_cnt + 1; rx_last <= rx_data; end
    sclk_prev <= sclk;
    if (sclk && !sclk_prev) rises <= rises + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [DW-1:0] d);
    wr_data = d; wr_valid = 1'b1; cyc(1); wr_valid = 1'b0;
  endtask

  task automatic wait_busy(input string req);
    int n = 0;
    while (!tx_busy && n < 1000) begin cyc(1); n++; end
    chk(req, tx_busy, 1);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (tx_busy && n < 5000) begin cyc(1); n++; end
  endtask

  function automatic logic abit(input logic [DW-1:0] d, input int k);
    if (k == 0) return 1'b0;
    if (k == DW + 1) return 1'b1;
    return d[k-1];
  endfunction

  // called at the sample point of the start bit
  task automatic async_bits(input logic [DW-1:0] d, input string req);
    for (int k = 0; k < DW + 2; k++) begin
      if (k > 0) cyc(BA);
      chk(req, txd, abit(d, k));
    end
  endtask

  // called on the first negedge showing tx_busy
  task automatic sync_frame(input logic [DW-1:0] d, input string req);
    int r0 = rises;
    for (int k = 0; k < DW; k++) begin
      cyc(k == 0 ? 1 + DIV/2 : DIV);
      chk({req, " low half"}, {sclk, txd}, {1'b0, d[k]});
      cyc(DIV);
      chk({req, " high half"}, {sclk, txd}, {1'b1, d[k]});
    end
    cyc(2 * DIV);
    chk("R8 pulse count", rises - r0, DW);
  endtask

  task automatic send_rx(input logic [DW-1:0] d, input logic stop);
    rxd_drv = 1'b0; cyc(BA);
    for (int i = 0; i < DW; i++) begin rxd_drv = d[i]; cyc(BA); end
    rxd_drv = stop; cyc(BA);
    rxd_drv = 1'b1; cyc(2 * BA);
  endtask

  initial begin
    cyc(150000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int unsigned s;
    logic [DW-1:0] d, d2;
    int c0;
    s = $urandom(32'd2024);
    cyc(5);
    // R1 reset state
    chk("R1 txd", txd, 1);            chk("R1 txd_oe", txd_oe, 0);
    chk("R1 sclk", sclk, 1);          chk("R1 sclk_oe", sclk_oe, 0);
    chk("R1 tx_empty", tx_empty, 1);  chk("R1 tx_busy", tx_busy, 0);
    chk("R1 rx_valid", rx_valid, 0);
    rst = 1'b0; cyc(3);

    // R2 asynchronous frames: directed then random
    port_en = 1; tx_en = 1; cyc(2);
    for (int i = 0; i < 6; i++) begin
      d = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : (i == 2) ? 8'hA5 : DW'($urandom);
      wr(d);
      wait_busy("R2 start");
      cyc(1 + BA/2);
      async_bits(d, "R2 frame bit");
      wait_idle();
      cyc(BA);
    end

    // R11 back-to-back plus write into full buffer
    d = DW'($urandom); d2 = DW'($urandom);
    wr(d);
    wait_busy("R11 first start");
    cyc(1);
    wr(d2);
    wr(8'h3C);                                 // buffer full: dropped
    chk("R11 buffer full", tx_empty, 0);
    cyc(BA/2 - 2);
    async_bits(d, "R11 first frame");
    cyc(BA);
    async_bits(d2, "R11 second frame");
    cyc(2 * BA);
    chk("R11 no third frame busy", tx_busy, 0);
    chk("R11 no third frame empty", tx_empty, 1);
    chk("R11 no third frame txd", txd, 1);

    // R3 / R4 port disabled while shifting, then re-enabled mid frame
    port_en = 0; cyc(2);
    d = DW'($urandom);
    wr(d);
    wait_busy("R3 internal shift");
    chk("R3 buffer moved", tx_empty, 1);
    cyc(1 + BA/2);
    for (int k = 0; k < 4; k++) begin
      if (k > 0) cyc(BA);
      chk("R3 txd parked", {txd, txd_oe}, 2'b10);
    end
    port_en = 1;
    for (int k = 4; k < DW + 2; k++) begin
      cyc(BA);
      chk("R4 mid-frame bit", txd, abit(d, k));
    end
    wait_idle(); cyc(BA);

    // R5 clearing tx_en mid-frame in asynchronous mode
    wr(8'h96);
    wait_busy("R5 start");
    cyc(1 + BA/2 + 2 * BA);
    tx_en = 0;
    cyc(1);
    chk("R5 busy cleared", tx_busy, 0);
    chk("R5 buffer empty", tx_empty, 1);
    cyc(1);
    chk("R5 txd idle", txd, 1);
    wr(8'h5A);
    cyc(3 * BA);
    chk("R5 write ignored busy", tx_busy, 0);
    chk("R5 write ignored empty", tx_empty, 1);
    tx_en = 1; cyc(4 * DIV);
    chk("R5 nothing stale", tx_busy, 0);
    chk("R5 txd still idle", txd, 1);

    // R6 asynchronous reception
    rx_en = 1; cyc(BA);
    for (int i = 0; i < 5; i++) begin
      d = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : DW'($urandom);
      c0 = rx_cnt;
      send_rx(d, 1'b1);
      chk("R6 one byte received", rx_cnt - c0, 1);
      chk("R6 byte value", rx_last, d);
    end
    c0 = rx_cnt;
    send_rx(8'h81, 1'b0);
    chk("R6 bad stop dropped", rx_cnt - c0, 0);
    c0 = rx_cnt;
    send_rx(8'h42, 1'b1);
    chk("R6 recovers after bad stop", rx_last, 8'h42);

    // R7 receive disabled either way
    rx_en = 0; c0 = rx_cnt;
    send_rx(8'h77, 1'b1);
    chk("R7 rx_en low", rx_cnt - c0, 0);
    rx_en = 1; port_en = 0; cyc(BA);
    send_rx(8'h66, 1'b1);
    chk("R7 port_en low", rx_cnt - c0, 0);
    port_en = 1; cyc(BA);

    // R8 / R9 synchronous master with loop-back
    sync_mode = 1; loop = 1; cyc(4);
    chk("R8 sclk_oe on", sclk_oe, 1);
    chk("R8 sclk idle high", sclk, 1);
    for (int i = 0; i < 5; i++) begin
      d = (i == 0) ? 8'h3C : (i == 1) ? 8'h01 : DW'($urandom);
      c0 = rx_cnt;
      wr(d);
      wait_busy("R8 start");
      sync_frame(d, "R8 bit");
      chk("R9 sync receive count", rx_cnt - c0, 1);
      chk("R9 sync receive value", rx_last, d);
      wait_idle(); cyc(BS);
    end
    port_en = 0; cyc(2);
    chk("R8 sclk parked when port off", {sclk, sclk_oe}, 2'b10);
    port_en = 1; cyc(2);

    // R10 only tx_en cleared: frame carries on for reception
    d = DW'($urandom);
    c0 = rx_cnt;
    wr(d);
    wait_busy("R10 start");
    tx_en = 0;
    sync_frame(d, "R10 frame continues");
    chk("R10 received", rx_last, d);
    chk("R10 received count", rx_cnt - c0, 1);
    tx_en = 1; wait_idle(); cyc(BS);

    // R10 both cleared: stops at once
    c0 = rx_cnt;
    wr(8'hC3);
    wait_busy("R10 second start");
    cyc(1 + DIV/2 + 2 * BS);
    tx_en = 0; rx_en = 0;
    cyc(1);
    chk("R10 both cleared busy", tx_busy, 0);
    chk("R10 both cleared empty", tx_empty, 1);
    cyc(10 * BS);
    chk("R10 no byte", rx_cnt - c0, 0);
    chk("R10 sclk idle", sclk, 1);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule